// File: doc/BRIEF.md
# Accumulator Processor with Interrupt Cycle

This block is a small processor built around one accumulator. It runs a fixed sequence of states against a single shared memory that holds both program and data. Each instruction is fetched from the location held in the program counter, decoded, and executed. After execution the processor checks for an interrupt before it fetches the next instruction. Every memory transfer goes through an address register and a data buffer register. The memory is synchronous, word addressed, and returns read data one cycle after the read strobe.

A 16-bit instruction carries the operation code in bits 15:12 and a 12-bit operand address in bits 11:0. The opcodes are: 0x1 load AC from memory, 0x5 add memory to AC, 0x2 store AC to memory, 0x8 jump, 0xC enable interrupts, 0xD disable interrupts, 0xE return from interrupt and 0x0 halt. Every other code does nothing. The interrupt request is a level input. When it is accepted, the processor saves the program counter in a save register, disables interrupts and continues at the handler address presented on an input.

Top module: `acc_cpu`

## Requirements
- R1: During reset and in the first cycle after reset, no memory strobe is asserted and `halted` is low. The PC, the AC and the interrupt enable are cleared, so the first fetch reads address 0 and interrupts start disabled.
- R2: An instruction cycle is: address setup (1 cycle), read strobe at the PC (1 cycle), wait (1 cycle), decode (1 cycle), execute (1 cycle). The PC advances by one after each fetch.
- R3: A read strobe lasts one cycle and is never asserted on two consecutive cycles. Read data is taken in the cycle after the strobe.
- R4: Load (0x1) copies the addressed word into the AC. Add (0x5) adds the addressed word to the AC modulo 2^16. Each uses one operand read at the instruction's address field and takes 9 cycles in total.
- R5: Store (0x2) asserts one write cycle at the address field, with the AC value on the write data. The instruction takes 8 cycles.
- R6: Jump (0x8) makes the next fetch read the address field.
- R7: Opcodes 0xC and 0xD set and clear the interrupt enable. Codes without a defined meaning change nothing apart from advancing the PC. These instructions and jump take 6 cycles.
- R8: The interrupt check follows every execute phase. With the enable set and the request high, the PC is saved, the enable is cleared and the next fetch reads `handler_addr`. Otherwise the next fetch uses the PC.
- R9: Return (0xE) restores the saved PC and sets the interrupt enable.
- R10: A request held high while interrupts are disabled is not taken. It is taken at the first check after an enable.
- R11: Halt (0x0) raises `halted` in the cycle after its execute phase and keeps it high until reset, with no further memory access.
- R12: The read and write strobes are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Level interrupt request |
| handler_addr | input | 12 | Start address of the interrupt handler |
| mem_addr | output | 12 | Memory address, from the address register |
| mem_rd | output | 1 | Read strobe; data is returned on the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data, from the buffer register |
| mem_rdata | input | 16 | Read data from memory |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The assertions check on every cycle that the two strobes are exclusive, that a read is never followed by another read, and that halt is final and quiet. They also check that an accepted interrupt clears the enable and leads to a fetch at the handler address two cycles later. The bench's scenarios are needed for the rest: arithmetic results and their wrap-around, jump targets, no-op codes, the resumed program flow after a return, and a request held pending through a disabled stretch. To show these, the bench runs a program with two interrupts against a behavioural model and compares the memory bus on every cycle.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int AW  = 12,
  parameter int OPW = 4,
  localparam int DW = AW + OPW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq,
  input  logic [AW-1:0] handler_addr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          halted
);

  localparam logic [OPW-1:0] OP_HALT = 'h0;
  localparam logic [OPW-1:0] OP_LOAD = 'h1;
  localparam logic [OPW-1:0] OP_STOR = 'h2;
  localparam logic [OPW-1:0] OP_ADD  = 'h5;
  localparam logic [OPW-1:0] OP_JMP  = 'h8;
  localparam logic [OPW-1:0] OP_EI   = 'hC;
  localparam logic [OPW-1:0] OP_DI   = 'hD;
  localparam logic [OPW-1:0] OP_RETI = 'hE;

  typedef enum logic [3:0] {
    S_IAC, S_IF, S_IWT, S_IOD, S_EXE,
    S_OF, S_OWT, S_DO, S_OSET, S_OS,
    S_INTC, S_HALT
  } state_t;

  state_t        st;
  logic [AW-1:0] pc, mar, spc;
  logic [DW-1:0] mbr, ir, ac;
  logic          ie;
  logic [OPW-1:0] op;
  logic          at_intc;

  assign op        = ir[DW-1:AW];
  assign mem_addr  = mar;
  assign mem_rd    = (st == S_IF) || (st == S_OF);
  assign mem_wr    = (st == S_OS);
  assign mem_wdata = mbr;
  assign halted    = (st == S_HALT);
  assign at_intc   = (st == S_INTC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IAC;
      pc  <= '0;
      mar <= '0;
      spc <= '0;
      mbr <= '0;
      ir  <= '0;
      ac  <= '0;
      ie  <= 1'b0;
    end else begin
      unique case (st)
        S_IAC: begin
          mar <= pc;
          st  <= S_IF;
        end
        S_IF:  st <= S_IWT;
        S_IWT: begin
          mbr <= mem_rdata;
          pc  <= pc + 1'b1;
          st  <= S_IOD;
        end
        S_IOD: begin
          ir  <= mbr;
          mar <= mbr[AW-1:0];
          st  <= S_EXE;
        end
        S_EXE: begin
          st <= S_INTC;
          case (op)
            OP_LOAD, OP_ADD: st <= S_OF;
            OP_STOR:         st <= S_OSET;
            OP_JMP:          pc <= ir[AW-1:0];
            OP_EI:           ie <= 1'b1;
            OP_DI:           ie <= 1'b0;
            OP_RETI: begin
              pc <= spc;
              ie <= 1'b1;
            end
            OP_HALT:         st <= S_HALT;
            default: ;
          endcase
        end
        S_OF:  st <= S_OWT;
        S_OWT: begin
          mbr <= mem_rdata;
          st  <= S_DO;
        end
        S_DO: begin
          ac <= (op == OP_ADD) ? ac + mbr : mbr;
          st <= S_INTC;
        end
        S_OSET: begin
          mbr <= ac;
          st  <= S_OS;
        end
        S_OS:  st <= S_INTC;
        S_INTC: begin
          if (ie && irq) begin
            spc <= pc;
            pc  <= handler_addr;
            ie  <= 1'b0;
          end
          st <= S_IAC;
        end
        S_HALT: st <= S_HALT;
        default: st <= S_IAC;
      endcase
    end
  end

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic [AW-1:0] handler_addr,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          halted,
  input logic          at_intc,
  input logic          ie
);

  logic take;
  assign take = at_intc && ie && irq;

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R3
  read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  // R11
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R11
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !mem_wr));

  // R8
  take_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !ie);

  // R8
  take_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ##1 (mem_rd && mem_addr == $past(handler_addr, 2)));

endmodule

bind acc_cpu acc_cpu_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq(irq), .handler_addr(handler_addr),
  .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .halted(halted), .at_intc(at_intc), .ie(ie)
);

// File: tb/acc_cpu_tb.sv
`timescale 1ns/1ps
module acc_cpu_tb_top;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int MW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          irq = 1'b0;
  logic [AW-1:0] haddr = 12'h800;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr, halted;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  logic [DW-1:0] ram [MW];
  logic [DW-1:0] ref_mem [MW];
  logic [30:0]   exp_q [$];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  acc_cpu #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq(irq), .handler_addr(haddr),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted)
  );

  always_ff @(posedge clk) begin
    if (mem_wr) ram[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= ram[mem_addr];
  end

  function automatic bit irq_at(int k);
    return (k >= 3 && k < 60) || (k >= 150 && k < 190);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic void emit(bit h, bit rd, bit wr, int a, int wd);
    exp_q.push_back({h, rd, wr, a[11:0], wd[15:0]});
  endfunction

  task automatic build_model();
    int pc = 0, ac = 0, spc = 0, op, a;
    bit ie = 0, done = 0;
    logic [15:0] ins;
    while (!done) begin
      emit(0, 0, 0, 0, 0);
      emit(0, 1, 0, pc, 0);
      ins = ref_mem[pc];
      emit(0, 0, 0, 0, 0);
      pc = (pc + 1) % MW;
      emit(0, 0, 0, 0, 0);
      emit(0, 0, 0, 0, 0);
      op = ins[15:12];
      a  = ins[11:0];
      case (op)
        1, 5: begin
          emit(0, 1, 0, a, 0);
          emit(0, 0, 0, 0, 0);
          emit(0, 0, 0, 0, 0);
          ac = (op == 1) ? ref_mem[a] : (ac + ref_mem[a]) & 16'hFFFF;
        end
        2: begin
          emit(0, 0, 0, 0, 0);
          emit(0, 0, 1, a, ac);
          ref_mem[a] = ac[15:0];
        end
        8:  pc = a;
        12: ie = 1;
        13: ie = 0;
        14: begin pc = spc; ie = 1; end
        0: begin
          for (int i = 0; i < 8; i++) emit(1, 0, 0, 0, 0);
          done = 1;
        end
        default: ;
      endcase
      if (!done) begin
        bit take = ie && irq_at(exp_q.size());
        emit(0, 0, 0, 0, 0);
        if (take) begin spc = pc; pc = haddr; ie = 0; end
      end
    end
  endtask

  task automatic load_prog();
    logic [15:0] p [23] = '{
      16'h1100, 16'h5101, 16'h2200, 16'h7000, 16'hC000, 16'hD000,
      16'h800A, 16'h0000, 16'h0000, 16'h0000,
      16'h2201, 16'h1102, 16'h5102, 16'h2202, 16'hF000,
      16'h1100, 16'h5101, 16'h2203, 16'h3000, 16'h9000,
      16'hC000, 16'h2204, 16'h0000 };
    for (int i = 0; i < MW; i++) ram[i] = '0;
    for (int i = 0; i < 23; i++) ram[i] = p[i];
    ram[12'h800] = 16'h1900;
    ram[12'h801] = 16'h5901;
    ram[12'h802] = 16'h2900;
    ram[12'h803] = 16'hE000;
    ram[12'h100] = 16'h1234;
    ram[12'h101] = 16'hF000;
    ram[12'h102] = 16'h4321;
    ram[12'h900] = 16'h0000;
    ram[12'h901] = 16'h0001;
    for (int i = 0; i < MW; i++) ref_mem[i] = ram[i];
  endtask

  function automatic string bus_tag(logic [30:0] e);
    if (e[30]) return "R11 halt";
    if (e[28]) return "R5 write";
    if (e[29]) return "R2 read";
    return "R12 idle";
  endfunction

  initial begin
    load_prog();
    build_model();
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!mem_rd && !mem_wr && !halted, "R1 reset strobes",
        {29'd0, halted, mem_rd, mem_wr}, 32'd0);
    for (int k = 0; k < exp_q.size(); k++) begin
      logic [30:0] e;
      logic [30:0] act;
      bit ok;
      if (k > 0) @(negedge clk);
      rst_n = 1'b1;
      e   = exp_q[k];
      act = {halted, mem_rd, mem_wr, mem_addr, mem_wdata};
      ok  = (act[30:28] == e[30:28]) &&
            (!(e[29] || e[28]) || act[27:16] == e[27:16]) &&
            (!e[28] || act[15:0] == e[15:0]);
      chk(ok, bus_tag(e), {1'b0, act}, {1'b0, e});
      if (k == 1)   chk(mem_rd && mem_addr == 12'h000, "R1 first fetch", mem_addr, 0);
      if (k == 27)  chk(mem_rd && mem_addr == 12'h003, "R7 before no-op", mem_addr, 3);
      if (k == 33)  chk(mem_rd && mem_addr == 12'h004, "R7 no-op skipped", mem_addr, 4);
      if (k == 39)  chk(mem_rd && mem_addr == 12'h800, "R8 handler fetch", mem_addr, 12'h800);
      if (k == 71)  chk(mem_rd && mem_addr == 12'h005, "R9 resume fetch", mem_addr, 5);
      if (k == 83)  chk(mem_rd && mem_addr == 12'h00A, "R6 jump target", mem_addr, 10);
      if (k == 155) chk(mem_rd && mem_addr == 12'h013, "R10 held while disabled", mem_addr, 19);
      if (k == 167) chk(mem_rd && mem_addr == 12'h800, "R10 taken after enable", mem_addr, 12'h800);
      if (k == 211) chk(halted, "R11 halted", {31'd0, halted}, 1);
      irq = irq_at(k);
    end
    @(negedge clk);
    chk(ram[12'h200] == 16'h0234, "R4 add wraps", ram[12'h200], 16'h0234);
    chk(ram[12'h202] == 16'h8642, "R4 add", ram[12'h202], 16'h8642);
    chk(ram[12'h203] == 16'h0234, "R4 reload", ram[12'h203], 16'h0234);
    chk(ram[12'h201] == 16'h0001, "R5 store after return", ram[12'h201], 1);
    chk(ram[12'h900] == 16'h0002, "R8 two interrupts", ram[12'h900], 2);
    chk(ram[12'h204] == 16'h0002, "R9 flow resumed", ram[12'h204], 2);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #50000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule